// File: doc/BRIEF.md
# Cascadable Up/Down Capture Counter

This block holds two counter slices, A and B, each `CNT_W` bits wide (8 by default). Each slice runs on its own clock, counts up or down while its run input is high, and wraps around at either end of its range. The cascade input joins the two slices into one counter of twice the width. Slice A is the low half and slice B the high half, and B then advances only when A rolls over.

A capture unit picks one of four capture sources. It passes the chosen source through a synchronizer in each slice's clock domain and looks for the selected kind of edge. On a valid edge the slice copies its present count into its own shadow register and pulses its interrupt for one cycle. Each slice detects the edge on its own. In the cascaded arrangement the two halves can therefore capture on different cycles when the clocks are unrelated. The source selection and edge selection inputs must only change while both slices are stopped.

Top module: `cap_cascade_counter`

## Requirements
- R1: A synchronous reset loads all ones into both counters, clears both shadow registers and drives both interrupts low.
- R2: With cascade low and its run input high, a slice counting up (down input 0) adds one per clock and goes from all ones to zero.
- R3: With cascade low and its run input high, a slice counting down (down input 1) subtracts one per clock and goes from zero to all ones.
- R4: With cascade high, slice B follows run_a and down_a and steps only in a cycle where slice A steps from its end value (all ones when counting up, zero when counting down). The pair therefore wraps between 0xFFFF and 0x0000 by default. In this mode clk_b must be the same clock as clk_a.
- R5: While a slice's effective run input is low, its count holds and no capture or interrupt takes place in that slice.
- R6: cap_func selects the capture edge: 0 disables capture, 1 selects rising edges, 2 selects falling edges and 3 selects both edges.
- R7: cap_sel is the index into cap_src of the capture source: 0 is the 1 kHz tick, 1 is port pin 2, 2 is port pin 3 and 3 is the 32 kHz tick.
- R8: If the selected source changes before clock edge k of a slice, that slice loads its shadow register and raises its interrupt at edge k+2. The value stored is the count held between edges k+1 and k+2.
- R9: An interrupt is high for exactly one clock cycle per capture. A shadow register keeps its value until the next capture in that slice.
- R10: Each slice detects the capture condition on its own. When cascade is low, a slice whose run is low does not capture, even while the other slice captures the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of slice A |
| rst_a | input | 1 | Synchronous active-high reset, clk_a domain |
| clk_b | input | 1 | Clock of slice B (same as clk_a when cascaded) |
| rst_b | input | 1 | Synchronous active-high reset, clk_b domain |
| run_a | input | 1 | Enables counting and capture in slice A |
| run_b | input | 1 | Enables slice B when not cascaded |
| down_a | input | 1 | Direction of slice A: 1 counts down |
| down_b | input | 1 | Direction of slice B when not cascaded |
| cascade | input | 1 | Joins the slices into one wide counter |
| cap_func | input | 2 | Capture edge kind (R6) |
| cap_sel | input | 2 | Capture source index (R7) |
| cap_src | input | 4 | Raw capture sources, asynchronous |
| count_a | output | CNT_W | Count of slice A |
| count_b | output | CNT_W | Count of slice B |
| shadow_a | output | CNT_W | Captured count of slice A |
| shadow_b | output | CNT_W | Captured count of slice B |
| irq_a | output | 1 | One-cycle capture pulse, clk_a domain |
| irq_b | output | 1 | One-cycle capture pulse, clk_b domain |

## Verification
Each capture source is toggled through rising, falling and both-edge settings with edges of both polarities. This separates edge kinds that must capture from those that must be ignored, and tells the four source indices apart. The captures run against slices counting in opposite directions, with one slice stopped, so a wrong direction, a shared detector or a capture while halted shows up as a wrong shadow value or an extra interrupt. The cascaded runs step the pair across a low-byte rollover, wrap up from all ones to zero and then down from zero to all ones, which checks the carry and borrow between halves.

// File: rtl/cap_cnt_pkg.sv
package cap_cnt_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_in,
  input  edge_mode_t mode,
  output logic       hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_slice.sv
module cap_slice #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             down,
  input  logic             cap_en,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] shadow,
  output logic             irq,
  output logic             at_end
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= ALL_ONES;
      shadow <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (tick) count <= down ? count - 1'b1 : count + 1'b1;
      if (cap_en && hit) begin
        shadow <= count;
        irq    <= 1'b1;
      end
    end
  end

  assign at_end = down ? (count == '0) : (count == ALL_ONES);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R5
  halt_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> (!irq && $stable(shadow)));
  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !down && count == ALL_ONES) |=> (count == '0));
  // R3
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && down && count == '0) |=> (count == ALL_ONES));
endmodule

// File: rtl/cap_cascade_counter.sv
module cap_cascade_counter
  import cap_cnt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk_a,
  input  logic               rst_a,
  input  logic               clk_b,
  input  logic               rst_b,
  input  logic               run_a,
  input  logic               run_b,
  input  logic               down_a,
  input  logic               down_b,
  input  logic               cascade,
  input  logic [1:0]         cap_func,
  input  logic [SEL_W-1:0]   cap_sel,
  input  logic [NUM_SRC-1:0] cap_src,
  output logic [CNT_W-1:0]   count_a,
  output logic [CNT_W-1:0]   count_b,
  output logic [CNT_W-1:0]   shadow_a,
  output logic [CNT_W-1:0]   shadow_b,
  output logic               irq_a,
  output logic               irq_b
);
  localparam int NSLICE = 2;

  edge_mode_t mode;
  logic       raw_sel;
  logic       a_end, b_end;
  logic [NSLICE-1:0] clk_v, rst_v, tick_v, down_v, en_v, hit_v, irq_v, end_v;
  logic [CNT_W-1:0]  cnt_v [NSLICE];
  logic [CNT_W-1:0]  shd_v [NSLICE];

  assign mode    = edge_mode_t'(cap_func);
  assign raw_sel = cap_src[cap_sel];

  assign clk_v  = {clk_b, clk_a};
  assign rst_v  = {rst_b, rst_a};
  assign tick_v = {cascade ? (run_a && a_end) : run_b, run_a};
  assign down_v = {cascade ? down_a : down_b, down_a};
  assign en_v   = {cascade ? run_a : run_b, run_a};

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk_v[i]), .rst(rst_v[i]), .raw_in(raw_sel), .mode(mode),
      .hit(hit_v[i])
    );
    cap_slice #(.CNT_W(CNT_W)) u_slice (
      .clk(clk_v[i]), .rst(rst_v[i]), .tick(tick_v[i]), .down(down_v[i]),
      .cap_en(en_v[i]), .hit(hit_v[i]), .count(cnt_v[i]), .shadow(shd_v[i]),
      .irq(irq_v[i]), .at_end(end_v[i])
    );
  end

  assign a_end    = end_v[0];
  assign b_end    = end_v[1];
  assign count_a  = cnt_v[0];
  assign count_b  = cnt_v[1];
  assign shadow_a = shd_v[0];
  assign shadow_b = shd_v[1];
  assign irq_a    = irq_v[0];
  assign irq_b    = irq_v[1];

  // R4
  casc_hold_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (cascade && !run_a) |=> $stable(count_b));
  // R4
  casc_carry_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (cascade && run_a && !down_a && a_end && b_end) |=> (count_b == '0));
endmodule

// File: tb/cap_cascade_counter_bench.sv
module cap_cascade_counter_bench;
  localparam int PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_a = 0, run_b = 0, down_a = 0, down_b = 0, cascade = 0;
  logic [1:0] cap_func = 0, cap_sel = 0;
  logic [3:0] cap_src = 0;
  logic [W-1:0] count_a, count_b, shadow_a, shadow_b;
  logic irq_a, irq_b;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] ma, mb, last_a, last_b;
  logic [W-1:0] qa[$], qb[$];

  always #(PERIOD/2) clk = ~clk;

  cap_cascade_counter u_cap_cascade_counter (
    .clk_a(clk), .rst_a(rst), .clk_b(clk), .rst_b(rst),
    .run_a(run_a), .run_b(run_b), .down_a(down_a), .down_b(down_b),
    .cascade(cascade), .cap_func(cap_func), .cap_sel(cap_sel),
    .cap_src(cap_src), .count_a(count_a), .count_b(count_b),
    .shadow_a(shadow_a), .shadow_b(shadow_b), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference counters built from R1..R5
  always @(posedge clk) begin
    if (rst) begin
      ma <= '1; mb <= '1;
    end else begin
      if (run_a) ma <= down_a ? ma - 1'b1 : ma + 1'b1;
      if (cascade) begin
        if (run_a && (down_a ? (ma == '0) : (ma == '1)))
          mb <= down_a ? mb - 1'b1 : mb + 1'b1;
      end else if (run_b) mb <= down_b ? mb - 1'b1 : mb + 1'b1;
    end
  end

  function automatic string cnt_req(bit casc, bit run, bit dn);
    if (casc) return "R4";
    if (!run) return "R5";
    return dn ? "R3" : "R2";
  endfunction

  // monitor: pops expected captures, checks counts and held shadows
  always @(negedge clk) begin
    if (!rst) begin
      check(count_a == ma, cnt_req(1'b0, run_a, down_a), "count_a", count_a, ma);
      check(count_b == mb, cnt_req(cascade, cascade ? run_a : run_b,
            cascade ? down_a : down_b), "count_b", count_b, mb);
      if (irq_a) begin
        if (qa.size() == 0) check(0, "R6", "unexpected irq_a", 1, 0);
        else begin
          last_a = qa.pop_front();
          check(shadow_a == last_a, "R8", "shadow_a", shadow_a, last_a);
        end
      end else check(shadow_a == last_a, "R9", "shadow_a held", shadow_a, last_a);
      if (irq_b) begin
        if (qb.size() == 0) check(0, "R10", "unexpected irq_b", 1, 0);
        else begin
          last_b = qb.pop_front();
          check(shadow_b == last_b, "R8", "shadow_b", shadow_b, last_b);
        end
      end else check(shadow_b == last_b, "R9", "shadow_b held", shadow_b, last_b);
    end
  end

  // driver: changes a source, predicts captures per R8
  task automatic drive_edge(int idx, logic val, bit ea, bit eb);
    @(negedge clk); cap_src[idx] = val;
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (ea) qa.push_back(ma);
    if (eb) qb.push_back(mb);
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_cfg(logic [1:0] f, logic [1:0] s);
    @(negedge clk); run_a = 0; run_b = 0;
    @(negedge clk); cap_func = f; cap_sel = s;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; run_a = 0; run_b = 0;
    repeat (3) @(negedge clk);
    rst = 0; last_a = '0; last_b = '0;
  endtask

  initial begin
    last_a = '0; last_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(count_a == 8'hFF && count_b == 8'hFF, "R1", "counts", {count_b, count_a}, 16'hFFFF);
    check(shadow_a == 0 && shadow_b == 0, "R1", "shadows", {shadow_b, shadow_a}, 0);
    check(!irq_a && !irq_b, "R1", "irqs", {irq_b, irq_a}, 0);
    rst = 0;

    // R6 rise, R7 source 0: A up, B down
    stop_cfg(2'd1, 2'd0);
    @(negedge clk); down_a = 0; down_b = 1; run_a = 1; run_b = 1;
    repeat (5) @(negedge clk);
    drive_edge(0, 1'b1, 1, 1);
    drive_edge(0, 1'b0, 0, 0);            // R6 falling ignored
    drive_edge(1, 1'b1, 0, 0);            // R7 unselected source
    drive_edge(1, 1'b0, 0, 0);
    repeat (300) @(negedge clk);          // R2 R3 wrap both ways
    drive_edge(0, 1'b1, 1, 1);
    drive_edge(0, 1'b0, 0, 0);

    // R5: stopped, falling on source 1 does nothing
    stop_cfg(2'd2, 2'd1);
    drive_edge(1, 1'b1, 0, 0);
    drive_edge(1, 1'b0, 0, 0);
    @(negedge clk); run_a = 1; run_b = 1;
    drive_edge(1, 1'b1, 0, 0);            // R6 rising ignored in fall mode
    drive_edge(1, 1'b0, 1, 1);            // R6 falling captures

    // R6 both edges on source 2, R10 B stopped
    stop_cfg(2'd3, 2'd2);
    @(negedge clk); run_a = 1; run_b = 0;
    drive_edge(2, 1'b1, 1, 0);
    drive_edge(2, 1'b0, 1, 0);

    // R6 disabled on source 3, then rise on source 3
    stop_cfg(2'd0, 2'd3);
    @(negedge clk); run_a = 1; run_b = 1;
    drive_edge(3, 1'b1, 0, 0);
    drive_edge(3, 1'b0, 0, 0);
    stop_cfg(2'd1, 2'd3);
    @(negedge clk); run_a = 1; run_b = 1;
    drive_edge(3, 1'b1, 1, 1);
    drive_edge(3, 1'b0, 0, 0);

    // R4 cascade: up wraps FFFF->0000, carries, then down 0000->FFFF
    do_reset();
    stop_cfg(2'd1, 2'd0);
    @(negedge clk); cascade = 1; down_a = 0; run_b = 0; run_a = 1;
    @(negedge clk);
    check(count_a == 0 && count_b == 0, "R4", "16-bit up wrap", {count_b, count_a}, 0);
    repeat (260) @(negedge clk);
    check(count_b == 8'h01, "R4", "carry into high byte", count_b, 1);
    drive_edge(0, 1'b1, 1, 1);
    drive_edge(0, 1'b0, 0, 0);
    do_reset();
    @(negedge clk); cascade = 1; down_a = 0; run_a = 1;
    @(negedge clk); down_a = 1;
    @(negedge clk);
    check(count_a == 8'hFF && count_b == 8'hFF, "R4", "16-bit down wrap",
          {count_b, count_a}, 16'hFFFF);
    repeat (20) @(negedge clk);
    @(negedge clk); run_a = 0;
    repeat (3) @(negedge clk);

    check(qa.size() == 0 && qb.size() == 0, "R8", "missing captures",
          qa.size() + qb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule